// File: doc/BRIEF.md
# Cache Line Lock State Array

This block holds the per-line bookkeeping bits of an N-set, 8-way set-associative cache. Every line carries a valid flag, an instruction-lock flag and a data-lock flag. A replacement selector presents a set index and gets back, in the same cycle, the valid, instruction-lock, data-lock and combined locked masks for the eight ways of that set. A way whose locked bit is set must not be picked as a victim, whether or not it holds valid data.

State changes come from three places. A set/way write port carries allocate, lock, unlock and invalidate commands. Three flash-clear strobes each act on the whole array in one cycle. A line-event port reports a store-invalidate or a castout refill for one line. A store-invalidate on a locked line drops only the valid flag, so the line keeps its lock and stays out of replacement. A later refill of that line makes it valid again with the lock kept.

Top module: `line_lock_array`

## Requirements
- R1: After a synchronous active-low reset, every valid, instruction-lock and data-lock bit of every line reads 0.
- R2: Write command codes on `wr_op` are: 0 allocate (valid set to 1), 1 instruction lock (ilock set to 1), 2 data lock (dlock set to 1). Each touches only the named bit of the addressed line.
- R3: Code 3 (unlock) clears both the instruction lock and the data lock of the addressed line and leaves its valid bit unchanged.
- R4: Code 4 (line invalidate) clears the valid bit and both lock bits of the addressed line. Codes 5, 6 and 7 change nothing.
- R5: `flash_ilock_clr` clears every instruction lock in the array in one cycle. Data locks and valid bits stay as they were.
- R6: `flash_dlock_clr` clears every data lock in the array in one cycle. Instruction locks and valid bits stay as they were.
- R7: `flash_inval` clears every valid, instruction-lock and data-lock bit in one cycle.
- R8: In a cycle with any flash strobe high, write-port commands and line events have no effect. Only the flash clears apply.
- R9: A store-invalidate event clears the valid bit of the addressed line and leaves both of its lock bits unchanged. If `evt_store_inv` and `evt_refill` are both high, the store-invalidate applies.
- R10: A refill event sets the valid bit of the addressed line if that line holds either lock. On a line with no lock it has no effect.
- R11: If a write command (any code) and an event address the same line in one cycle, the write applies and the event is ignored. If they address different lines, both apply.
- R12: `locked_mask` is the OR of the instruction-lock and data-lock bits of the set on `rd_set`, whatever the valid bits are. All four masks follow `rd_set` combinationally and show a state change in the cycle after the clock edge that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write-port command strobe |
| wr_op | input | 3 | Write command code (see R2 to R4) |
| wr_set | input | SET_W | Set addressed by the write command |
| wr_way | input | WAY_W | Way addressed by the write command |
| evt_store_inv | input | 1 | Store-invalidate event for the event line |
| evt_refill | input | 1 | Castout/push refill event for the event line |
| evt_set | input | SET_W | Set addressed by the event |
| evt_way | input | WAY_W | Way addressed by the event |
| flash_ilock_clr | input | 1 | Clear all instruction locks |
| flash_dlock_clr | input | 1 | Clear all data locks |
| flash_inval | input | 1 | Clear all valid and lock bits |
| rd_set | input | SET_W | Set whose masks are presented |
| valid_mask | output | NUM_WAYS | Valid bits of the presented set |
| ilock_mask | output | NUM_WAYS | Instruction-lock bits of the presented set |
| dlock_mask | output | NUM_WAYS | Data-lock bits of the presented set |
| locked_mask | output | NUM_WAYS | Ways of the presented set excluded from replacement |

## Verification
The bench starts with directed sequences. Each sequence places a line in one particular mix of valid and lock bits, then applies one command or event to it. These runs tell the lock-preserving events (store-invalidate and refill) apart from the commands that clear locks, and show that the two flash clears each act on their own lock kind only. A long pseudo-random run follows. It mixes commands, events that hit the same line or other lines, and rare flash strobes. After every cycle it reads all four masks of every set and compares them against a reference array kept by the bench. This exposes errors in priority order and in address decoding that the directed cases miss.

// File: rtl/lla_pkg.sv
// Package: shared types of the line lock state array.
// Assumes: command encodings are fixed, since the write port decodes them.
package lla_pkg;

    typedef enum logic [2:0] {
        CMD_ALLOC  = 3'd0,
        CMD_LOCK_I = 3'd1,
        CMD_LOCK_D = 3'd2,
        CMD_UNLOCK = 3'd3,
        CMD_INVAL  = 3'd4
    } line_cmd_e;

    typedef struct packed {
        logic valid;
        logic ilock;
        logic dlock;
    } line_bits_t;

endpackage

// File: rtl/lla_addr_dec.sv
// Module: lla_addr_dec
// Turns a (set, way) address plus an enable into a one-hot line select.
// Assumes: lines are numbered set*NUM_WAYS + way; an out-of-range set selects nothing.
module lla_addr_dec #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int LINES   = NUM_SETS * NUM_WAYS
) (
    input  logic             en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] way_idx,
    output logic [LINES-1:0] sel
);

    // Compare the address with every line number.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            sel[i] = en && (i == (int'(set_idx) * NUM_WAYS + int'(way_idx)));
        end
    end

endmodule

// File: rtl/lla_line_cell.sv
// Module: lla_line_cell
// Holds the valid and lock bits of one cache line and applies the update priority:
// full flash, then lock flashes, then a write command, then a line event.
// Assumes: the caller has already masked the event when the write port hits this line.
module lla_line_cell
    import lla_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flash_all,
    input  logic       flash_i,
    input  logic       flash_d,
    input  logic       wr_hit,
    input  logic [2:0] wr_cmd,
    input  logic       evt_hit,
    input  logic       store_inv,
    input  logic       refill,
    output line_bits_t bits
);

    line_bits_t nxt;
    logic       held;

    // Any lock bit keeps the line out of replacement.
    assign held = bits.ilock | bits.dlock;

    // Work out the next state from the prioritised request sources.
    always_comb begin
        nxt = bits;
        if (flash_all) begin
            nxt = '0;
        end else if (flash_i || flash_d) begin
            if (flash_i) nxt.ilock = 1'b0;
            if (flash_d) nxt.dlock = 1'b0;
        end else if (wr_hit) begin
            case (wr_cmd)
                CMD_ALLOC:  nxt.valid = 1'b1;
                CMD_LOCK_I: nxt.ilock = 1'b1;
                CMD_LOCK_D: nxt.dlock = 1'b1;
                CMD_UNLOCK: begin
                    nxt.ilock = 1'b0;
                    nxt.dlock = 1'b0;
                end
                CMD_INVAL:  nxt = '0;
                default:    nxt = bits;
            endcase
        end else if (evt_hit) begin
            if (store_inv) begin
                nxt.valid = 1'b0;
            end else if (refill && held) begin
                nxt.valid = 1'b1;
            end
        end
    end

    // Register the line state with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= nxt;
    end

endmodule

// File: rtl/lla_set_view.sv
// Module: lla_set_view
// Picks out the per-way bits of one set from the flat line vectors, combinationally.
// Assumes: an out-of-range set index reads as all zero.
module lla_set_view #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int LINES   = NUM_SETS * NUM_WAYS
) (
    input  logic [SET_W-1:0]    rd_set,
    input  logic [LINES-1:0]    valid_all,
    input  logic [LINES-1:0]    ilock_all,
    input  logic [LINES-1:0]    dlock_all,
    output logic [NUM_WAYS-1:0] valid_mask,
    output logic [NUM_WAYS-1:0] ilock_mask,
    output logic [NUM_WAYS-1:0] dlock_mask
);

    // Select the slice of the set that matches the index.
    always_comb begin
        valid_mask = '0;
        ilock_mask = '0;
        dlock_mask = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (rd_set == SET_W'(s)) begin
                valid_mask = valid_all[s*NUM_WAYS +: NUM_WAYS];
                ilock_mask = ilock_all[s*NUM_WAYS +: NUM_WAYS];
                dlock_mask = dlock_all[s*NUM_WAYS +: NUM_WAYS];
            end
        end
    end

endmodule

// File: rtl/line_lock_array.sv
// Module: line_lock_array (top)
// Per-line valid, instruction-lock and data-lock state of a set-associative cache.
// Has a set/way write port, a line-event port and three flash-clear strobes.
// Presents the masks of one set for a replacement selector.
// Assumes: NUM_SETS >= 2 and NUM_WAYS >= 2; a write and an event on the same line
// in one cycle resolve in favour of the write.
module line_lock_array
    import lla_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS),
    localparam int LINES   = NUM_SETS * NUM_WAYS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_op,
    input  logic [SET_W-1:0]    wr_set,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic                evt_store_inv,
    input  logic                evt_refill,
    input  logic [SET_W-1:0]    evt_set,
    input  logic [WAY_W-1:0]    evt_way,
    input  logic                flash_ilock_clr,
    input  logic                flash_dlock_clr,
    input  logic                flash_inval,
    input  logic [SET_W-1:0]    rd_set,
    output logic [NUM_WAYS-1:0] valid_mask,
    output logic [NUM_WAYS-1:0] ilock_mask,
    output logic [NUM_WAYS-1:0] dlock_mask,
    output logic [NUM_WAYS-1:0] locked_mask
);

    logic [LINES-1:0] wr_sel;
    logic [LINES-1:0] evt_sel;
    logic [LINES-1:0] valid_all;
    logic [LINES-1:0] ilock_all;
    logic [LINES-1:0] dlock_all;
    logic             evt_any;

    // An event is live when either event strobe is high.
    assign evt_any = evt_store_inv | evt_refill;

    // Decode the write-port address.
    lla_addr_dec #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_wr_dec (
        .en      (wr_en),
        .set_idx (wr_set),
        .way_idx (wr_way),
        .sel     (wr_sel)
    );

    // Decode the event-port address.
    lla_addr_dec #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_evt_dec (
        .en      (evt_any),
        .set_idx (evt_set),
        .way_idx (evt_way),
        .sel     (evt_sel)
    );

    // One state cell per line; the write select masks the event on the same line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_bits_t bits_q;

        lla_line_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .flash_all (flash_inval),
            .flash_i   (flash_ilock_clr),
            .flash_d   (flash_dlock_clr),
            .wr_hit    (wr_sel[g]),
            .wr_cmd    (wr_op),
            .evt_hit   (evt_sel[g] & ~wr_sel[g]),
            .store_inv (evt_store_inv),
            .refill    (evt_refill),
            .bits      (bits_q)
        );

        assign valid_all[g] = bits_q.valid;
        assign ilock_all[g] = bits_q.ilock;
        assign dlock_all[g] = bits_q.dlock;
    end

    // Present the masks of the requested set.
    lla_set_view #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_view (
        .rd_set     (rd_set),
        .valid_all  (valid_all),
        .ilock_all  (ilock_all),
        .dlock_all  (dlock_all),
        .valid_mask (valid_mask),
        .ilock_mask (ilock_mask),
        .dlock_mask (dlock_mask)
    );

    // A way with either lock is held out of replacement, whatever its valid bit.
    assign locked_mask = ilock_mask | dlock_mask;

endmodule

// File: rtl/lla_checker.sv
// Module: lla_checker
// Temporal properties of line_lock_array, observed at its ports.
// Assumes: attached through the bind statement at the end of this file.
module lla_checker #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_op,
    input logic [SET_W-1:0]    wr_set,
    input logic [WAY_W-1:0]    wr_way,
    input logic                evt_store_inv,
    input logic [SET_W-1:0]    evt_set,
    input logic [WAY_W-1:0]    evt_way,
    input logic                flash_ilock_clr,
    input logic                flash_dlock_clr,
    input logic                flash_inval,
    input logic [SET_W-1:0]    rd_set,
    input logic [NUM_WAYS-1:0] valid_mask,
    input logic [NUM_WAYS-1:0] ilock_mask,
    input logic [NUM_WAYS-1:0] dlock_mask
);

    logic any_flash;
    logic same_line;

    // Combine the strobes and compare the two port addresses for the antecedents.
    assign any_flash = flash_ilock_clr | flash_dlock_clr | flash_inval;
    assign same_line = wr_en && (wr_set == evt_set) && (wr_way == evt_way);

    assert_flash_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flash_inval |=> (valid_mask == '0) && (ilock_mask == '0) && (dlock_mask == '0));

    assert_flash_ilock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flash_ilock_clr |=> (ilock_mask == '0));

    assert_flash_dlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flash_dlock_clr |=> (dlock_mask == '0));

    assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd3 && !any_flash) |=>
            (rd_set != $past(wr_set)) ||
            (!ilock_mask[$past(wr_way)] && !dlock_mask[$past(wr_way)]));

    assert_store_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_store_inv && !any_flash && !same_line) |=>
            (rd_set != $past(evt_set)) || !valid_mask[$past(evt_way)]);

endmodule

bind line_lock_array lla_checker #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_op           (wr_op),
    .wr_set          (wr_set),
    .wr_way          (wr_way),
    .evt_store_inv   (evt_store_inv),
    .evt_set         (evt_set),
    .evt_way         (evt_way),
    .flash_ilock_clr (flash_ilock_clr),
    .flash_dlock_clr (flash_dlock_clr),
    .flash_inval     (flash_inval),
    .rd_set          (rd_set),
    .valid_mask      (valid_mask),
    .ilock_mask      (ilock_mask),
    .dlock_mask      (dlock_mask)
);

// File: tb/line_lock_array_tb.sv
`timescale 1ns/100ps
module line_lock_array_tb;

    localparam int NS = 4;
    localparam int NW = 8;
    localparam int SW = $clog2(NS);
    localparam int WW = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, evt_store_inv, evt_refill;
    logic [2:0]    wr_op;
    logic [SW-1:0] wr_set, evt_set, rd_set;
    logic [WW-1:0] wr_way, evt_way;
    logic          flash_ilock_clr, flash_dlock_clr, flash_inval;
    logic [NW-1:0] valid_mask, ilock_mask, dlock_mask, locked_mask;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;
    logic mv [NS][NW];
    logic mi [NS][NW];
    logic md [NS][NW];
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    line_lock_array #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_set(wr_set),
        .wr_way(wr_way), .evt_store_inv(evt_store_inv), .evt_refill(evt_refill),
        .evt_set(evt_set), .evt_way(evt_way), .flash_ilock_clr(flash_ilock_clr),
        .flash_dlock_clr(flash_dlock_clr), .flash_inval(flash_inval), .rd_set(rd_set),
        .valid_mask(valid_mask), .ilock_mask(ilock_mask), .dlock_mask(dlock_mask),
        .locked_mask(locked_mask)
    );

    task automatic idle_inputs();
        wr_en = 0; wr_op = 0; wr_set = 0; wr_way = 0;
        evt_store_inv = 0; evt_refill = 0; evt_set = 0; evt_way = 0;
        flash_ilock_clr = 0; flash_dlock_clr = 0; flash_inval = 0;
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; mi[s][w] = 0; md[s][w] = 0;
            end
    endtask

    // Reference update written from the requirements.
    task automatic model_apply();
        if (flash_inval) begin
            model_reset();                                       // R7
        end else if (flash_ilock_clr || flash_dlock_clr) begin   // R5 R6 R8
            for (int s = 0; s < NS; s++)
                for (int w = 0; w < NW; w++) begin
                    if (flash_ilock_clr) mi[s][w] = 0;
                    if (flash_dlock_clr) md[s][w] = 0;
                end
        end else begin
            if (wr_en) begin
                case (wr_op)
                    3'd0: mv[wr_set][wr_way] = 1;
                    3'd1: mi[wr_set][wr_way] = 1;
                    3'd2: md[wr_set][wr_way] = 1;
                    3'd3: begin mi[wr_set][wr_way] = 0; md[wr_set][wr_way] = 0; end
                    3'd4: begin
                        mv[wr_set][wr_way] = 0; mi[wr_set][wr_way] = 0; md[wr_set][wr_way] = 0;
                    end
                    default: ;
                endcase
            end
            if ((evt_store_inv || evt_refill) &&
                !(wr_en && wr_set == evt_set && wr_way == evt_way)) begin  // R11
                if (evt_store_inv) mv[evt_set][evt_way] = 0;               // R9
                else if (mi[evt_set][evt_way] || md[evt_set][evt_way])
                    mv[evt_set][evt_way] = 1;                              // R10
            end
        end
    endtask

    // Read every set and compare all masks with the reference.
    task automatic check_all(input string tag);
        for (int s = 0; s < NS; s++) begin
            logic [NW-1:0] ev, ei, ed;
            for (int w = 0; w < NW; w++) begin
                ev[w] = mv[s][w]; ei[w] = mi[s][w]; ed[w] = md[s][w];
            end
            rd_set = SW'(s);
            #0.5;
            checks++;
            if ({valid_mask, ilock_mask, dlock_mask} !== {ev, ei, ed}) begin
                errors++;
                $display("FAIL %s set %0d: actual v=%b i=%b d=%b expected v=%b i=%b d=%b",
                         tag, s, valid_mask, ilock_mask, dlock_mask, ev, ei, ed);
            end
            checks++;
            if (locked_mask !== (ei | ed)) begin
                errors++;
                $display("FAIL R12 set %0d: actual locked=%b expected %b", s, locked_mask, ei | ed);
            end
        end
    endtask

    // Drive one cycle of stimulus, then check after the edge.
    task automatic step(input logic we, input logic [2:0] op, input int ws, input int ww,
                        input logic si, input logic rf, input int es, input int ew,
                        input logic fi, input logic fd, input logic fa, input string tag);
        @(negedge clk);
        wr_en = we; wr_op = op; wr_set = SW'(ws); wr_way = WW'(ww);
        evt_store_inv = si; evt_refill = rf; evt_set = SW'(es); evt_way = WW'(ew);
        flash_ilock_clr = fi; flash_dlock_clr = fd; flash_inval = fa;
        model_apply();
        @(posedge clk);
        #0.5;
        idle_inputs();
        check_all(tag);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rd_set = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2: allocate and lock commands touch only their own bit
        step(1, 3'd0, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd1, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd2, 2, 5, 0, 0, 0, 0, 0, 0, 0, "R2");   // locked while invalid (R12)
        // R3: unlock keeps valid
        step(1, 3'd3, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R9: store-invalidate on a locked line keeps its lock
        step(1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 3'd0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
        // R10: refill revalidates a locked line, ignores an unlocked one
        step(0, 3'd0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R10");
        step(0, 3'd0, 0, 0, 0, 1, 3, 7, 0, 0, 0, "R10");
        // R9: both event strobes, store-invalidate applies
        step(0, 3'd0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R9");
        // R4: line invalidate and unused codes
        step(1, 3'd4, 2, 5, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
        step(1, 3'd7, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R11: same line, write wins; different lines, both apply
        step(1, 3'd0, 3, 1, 1, 0, 3, 1, 0, 0, 0, "R11");
        step(1, 3'd1, 3, 2, 1, 0, 3, 1, 0, 0, 0, "R11");
        // R5 / R6: each lock flash spares the other kind
        for (int w = 0; w < NW; w++) begin
            step(1, 3'd1, 2, w, 0, 0, 0, 0, 0, 0, 0, "R2");
            step(1, (w % 2 == 0) ? 3'd2 : 3'd0, 2, w, 0, 0, 0, 0, 0, 0, 0, "R2");
        end
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R5");
        for (int w = 0; w < NW; w += 3) step(1, 3'd1, 1, w, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
        // R8: flash suppresses a same-cycle write and event
        step(1, 3'd2, 0, 4, 0, 1, 1, 0, 1, 0, 0, "R8");
        step(1, 3'd0, 0, 6, 1, 0, 1, 0, 0, 1, 0, "R8");
        // R7: full flash
        step(1, 3'd0, 3, 3, 0, 0, 0, 0, 0, 0, 1, "R7");

        // Pseudo-random sweep against the reference (R8, R11 and all commands)
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            rng = xs(rng); a = rng;
            rng = xs(rng); b = rng;
            step(a[0], a[3:1] % 3'd6, int'(a[5:4]), int'(a[8:6]),
                 a[9] & a[10], a[11] & a[12],
                 (b[0] & b[1]) ? int'(a[5:4]) : int'(b[3:2]),
                 (b[0] & b[1]) ? int'(a[8:6]) : int'(b[6:4]),
                 b[15:10] == 6'd1, b[21:16] == 6'd2, b[29:22] == 8'd3,
                 "R11 random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule